// File: doc/BRIEF.md
# Transactional Read-Set Mark Tracker

This block sits beside the tag array of a data cache and holds one mark bit for each 16-byte sub-block of every line. Software transactional memory code uses the marks to remember which locations are already in its read set. Any load can set, clear or test the mark of the sub-block it touches. A saturating loss counter records every event that may have dropped a mark. At commit, software reads the counter. A value of zero shows that no marked data was lost, so read-set validation needs no further work. Any other value sends software to its full validation path.

Line evictions and snooped remote writes or upgrades come in as event ports. Cache data, refill and the coherence protocol itself are modelled only by these events. A bulk mark reset, a counter clear and a context-switch notice arrive as single-cycle command pulses. The counter is always visible on `cnt_o`, and reading it means sampling that port.

Top module: `tm_mark_array`

## Requirements
- R1: Each line holds SUBS independent mark bits, one per 16-byte sub-block, addressed by `req_line_i` and `req_sub_i`. After reset every mark is clear and the counter is 0.
- R2: A valid request with `req_op_i`=1 (load-and-set) sets only the addressed mark.
- R3: A valid request with `req_op_i`=2 (load-and-clear) clears only the addressed mark.
- R4: Every valid request produces `rsp_valid_o` one cycle later. For `req_op_i`=3 (load-and-test), `rsp_mark_o` then carries the addressed mark as it stood before the request. For other ops `rsp_mark_o` is 0. Op 0 (plain load) and op 3 change no mark.
- R5: An eviction of a line with at least one mark raises the counter by 1 and clears all marks of that line. An eviction of an unmarked line changes nothing.
- R6: A snooped remote write or upgrade to a line with at least one mark raises the counter by 1 and clears all marks of that line. A snoop to an unmarked line changes nothing.
- R7: `clr_all_i` clears every mark and always raises the counter by 1.
- R8: The counter is 8 bits wide. Events in the same cycle add together, each counting 1. The counter saturates at 255 and never wraps.
- R9: `cnt_clr_i` sets the counter to 0 and takes precedence over any increment in the same cycle.
- R10: `ctx_sw_i` forces the counter to 255 and takes precedence over `cnt_clr_i` and over increments.
- R11: Eviction, snoop and bulk reset override a set on the same line in the same cycle. Whether marks were lost is judged on the marks held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request valid |
| req_op_i | input | 2 | 0 plain, 1 set mark, 2 clear mark, 3 test mark |
| req_line_i | input | 3 | Line index of request |
| req_sub_i | input | 2 | Sub-block index of request |
| evict_valid_i | input | 1 | Line eviction event |
| evict_line_i | input | 3 | Evicted line index |
| snoop_valid_i | input | 1 | Remote write/upgrade event |
| snoop_line_i | input | 3 | Snooped line index |
| clr_all_i | input | 1 | Clear every mark |
| cnt_clr_i | input | 1 | Clear loss counter |
| ctx_sw_i | input | 1 | Context switch, counter to maximum |
| rsp_valid_o | output | 1 | Response for request of previous cycle |
| rsp_mark_o | output | 1 | Tested mark value |
| cnt_o | output | 8 | Loss counter |

## Verification
The hardest case to reach is the overlap of several events in one cycle. Examples are an eviction and a snoop to two marked lines together with a bulk reset, or a set landing on a line that is being evicted. Another hard case is keeping those overlaps up near the counter limit. The bench first builds known mark patterns through sweeps of set and clear over every line and sub-block. It then fires overlapping events against lines chosen to be marked or unmarked. It also drives the counter to saturation with repeated bulk resets before it mixes in clears and context switches.

// File: rtl/tm_mark_pkg.sv
package tm_mark_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TEST = 2'd3
  } mark_op_e;
endpackage

// File: rtl/tm_mark_line.sv
module tm_mark_line #(
  parameter int SUBS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SUBS-1:0] set_i,
  input  logic [SUBS-1:0] clr_i,
  input  logic            kill_i,
  output logic [SUBS-1:0] marks_o
);
  logic [SUBS-1:0] marks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     marks_q <= '0;
    else if (kill_i) marks_q <= '0;  // line loss beats a set
    else             marks_q <= (marks_q & ~clr_i) | set_i;
  end

  assign marks_o = marks_q;
endmodule

// File: rtl/tm_mark_cnt.sv
module tm_mark_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctx_sw_i,
  input  logic             clr_i,
  input  logic [1:0]       inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (ctx_sw_i)    cnt_q <= '1;
    else if (clr_i)       cnt_q <= '0;
    else if (sum[CNT_W])  cnt_q <= '1;
    else                  cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tm_mark_array.sv
module tm_mark_array
  import tm_mark_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int SUBS      = 4,
  parameter int CNT_W     = 8,
  localparam int LW = $clog2(NUM_LINES),
  localparam int SW = $clog2(SUBS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [LW-1:0]    req_line_i,
  input  logic [SW-1:0]    req_sub_i,
  input  logic             evict_valid_i,
  input  logic [LW-1:0]    evict_line_i,
  input  logic             snoop_valid_i,
  input  logic [LW-1:0]    snoop_line_i,
  input  logic             clr_all_i,
  input  logic             cnt_clr_i,
  input  logic             ctx_sw_i,
  output logic             rsp_valid_o,
  output logic             rsp_mark_o,
  output logic [CNT_W-1:0] cnt_o
);
  mark_op_e op;
  logic [SUBS-1:0] sub_oh;
  logic [NUM_LINES-1:0][SUBS-1:0] marks;
  logic [NUM_LINES-1:0] line_any;
  logic evict_hit, snoop_hit;
  logic [1:0] inc_amt;
  logic rsp_valid_q, rsp_mark_q;

  assign op     = mark_op_e'(req_op_i);
  assign sub_oh = SUBS'(1) << req_sub_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit, kill;
    logic [SUBS-1:0] set_v, clr_v;
    assign hit   = req_valid_i && (req_line_i == LW'(g));
    assign set_v = (hit && op == OP_SET) ? sub_oh : '0;
    assign clr_v = (hit && op == OP_CLR) ? sub_oh : '0;
    assign kill  = clr_all_i
                 || (evict_valid_i && evict_line_i == LW'(g))
                 || (snoop_valid_i && snoop_line_i == LW'(g));
    tm_mark_line #(.SUBS(SUBS)) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_v),
      .clr_i   (clr_v),
      .kill_i  (kill),
      .marks_o (marks[g])
    );
    assign line_any[g] = |marks[g];
  end

  // loss is judged on marks held before this cycle
  assign evict_hit = evict_valid_i && line_any[evict_line_i];
  assign snoop_hit = snoop_valid_i && line_any[snoop_line_i];
  assign inc_amt   = 2'(evict_hit) + 2'(snoop_hit) + 2'(clr_all_i);

  tm_mark_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctx_sw_i (ctx_sw_i),
    .clr_i    (cnt_clr_i),
    .inc_i    (inc_amt),
    .cnt_o    (cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_mark_q  <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_mark_q  <= req_valid_i && op == OP_TEST && marks[req_line_i][req_sub_i];
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_mark_o  = rsp_mark_q;
endmodule

// File: rtl/tm_mark_array_chk.sv
module tm_mark_array_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       req_op_i,
  input logic             clr_all_i,
  input logic             cnt_clr_i,
  input logic             ctx_sw_i,
  input logic             rsp_valid_o,
  input logic             rsp_mark_o,
  input logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  a_r10_ctx_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_sw_i |=> cnt_o == MAX);

  a_r9_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i && !ctx_sw_i |=> cnt_o == '0);

  a_r8_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == MAX && !cnt_clr_i && !ctx_sw_i |=> cnt_o == MAX);

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clr_i && !ctx_sw_i |=> cnt_o >= $past(cnt_o));

  a_r7_bump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i && !cnt_clr_i && !ctx_sw_i && cnt_o != MAX |=> cnt_o != $past(cnt_o));

  a_r4_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r4_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r4_mark_test_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i != 2'd3 |=> !rsp_mark_o);
endmodule

bind tm_mark_array tm_mark_array_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .clr_all_i   (clr_all_i),
  .cnt_clr_i   (cnt_clr_i),
  .ctx_sw_i    (ctx_sw_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_mark_o  (rsp_mark_o),
  .cnt_o       (cnt_o)
);

// File: tb/tm_mark_array_tb.sv
module tm_mark_array_tb;
  localparam int NL = 8;
  localparam int S  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rv = 0, ev = 0, sn = 0, ca = 0, cc = 0, cs = 0;
  logic [1:0] rop = '0;
  logic [2:0] rline = '0, evl = '0, snl = '0;
  logic [1:0] rsub = '0;
  logic rsp_valid_o, rsp_mark_o;
  logic [7:0] cnt_o;

  logic [S-1:0] mk [NL];
  int cnt_m = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tm_mark_array u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(rv), .req_op_i(rop), .req_line_i(rline), .req_sub_i(rsub),
    .evict_valid_i(ev), .evict_line_i(evl),
    .snoop_valid_i(sn), .snoop_line_i(snl),
    .clr_all_i(ca), .cnt_clr_i(cc), .ctx_sw_i(cs),
    .rsp_valid_o(rsp_valid_o), .rsp_mark_o(rsp_mark_o), .cnt_o(cnt_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic em;
    int inc, ec;
    em  = rv && rop == 2'd3 && mk[rline][rsub];
    inc = int'(ev && (|mk[evl])) + int'(sn && (|mk[snl])) + int'(ca);
    ec  = cs ? 255 : cc ? 0 : ((cnt_m + inc > 255) ? 255 : cnt_m + inc);
    if (rv && rop == 2'd1) mk[rline][rsub] = 1'b1;
    if (rv && rop == 2'd2) mk[rline][rsub] = 1'b0;
    if (ca) for (int l = 0; l < NL; l++) mk[l] = '0;
    if (ev) mk[evl] = '0;
    if (sn) mk[snl] = '0;
    cnt_m = ec;
    @(posedge clk); #1;
    chk(tag, "rsp_valid", int'(rsp_valid_o), int'(rv));
    chk(tag, "rsp_mark", int'(rsp_mark_o), int'(em));
    chk(tag, "cnt", int'(cnt_o), cnt_m);
    rv = 0; ev = 0; sn = 0; ca = 0; cc = 0; cs = 0;
  endtask

  task automatic req(input logic [1:0] op, input int l, input int s, input string tag);
    rv = 1; rop = op; rline = 3'(l); rsub = 2'(s);
    tick(tag);
  endtask

  task automatic test_all(input string tag);
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < S; s++) req(2'd3, l, s, tag);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) mk[l] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "cnt_reset", int'(cnt_o), 0);
    chk("R1", "rsp_reset", int'(rsp_valid_o), 0);
    test_all("R1");

    // R2 set pattern, R4 test reads back
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < S; s++)
        if ((l + s) % 3 == 0) req(2'd1, l, s, "R2");
    test_all("R2");
    // R4 plain load changes nothing
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < S; s++) req(2'd0, l, s, "R4");
    test_all("R4");
    // R3 clear a subset
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < S; s++)
        if (l % 2 == 0) req(2'd2, l, s, "R3");
    test_all("R3");

    // R5 evict every line: marked ones count
    for (int l = 0; l < NL; l++) begin ev = 1; evl = 3'(l); tick("R5"); end
    test_all("R5");

    // R6 snoops on marked and unmarked lines
    for (int l = 0; l < NL; l++) req(2'd1, l, (l * 3) % S, "R6");
    for (int l = 0; l < NL; l += 2) begin sn = 1; snl = 3'(l); tick("R6"); end
    for (int l = 0; l < NL; l += 2) begin sn = 1; snl = 3'(l); tick("R6"); end
    test_all("R6");

    // R7 bulk reset with and without marks
    ca = 1; tick("R7");
    ca = 1; tick("R7");
    test_all("R7");

    // R9 clear beats concurrent increments
    req(2'd1, 1, 1, "R9"); req(2'd1, 2, 2, "R9");
    cc = 1; ev = 1; evl = 3'd1; sn = 1; snl = 3'd2; ca = 1; tick("R9");
    test_all("R9");

    // R8 three events in one cycle add up
    req(2'd1, 4, 0, "R8"); req(2'd1, 5, 3, "R8");
    ev = 1; evl = 3'd4; sn = 1; snl = 3'd5; ca = 1; tick("R8");
    // R8 drive into saturation
    for (int i = 0; i < 260; i++) begin ca = 1; tick("R8"); end
    req(2'd1, 6, 1, "R8"); req(2'd1, 7, 2, "R8");
    ev = 1; evl = 3'd6; sn = 1; snl = 3'd7; ca = 1; tick("R8");

    // R10 context switch beats clear, then from zero
    cc = 1; tick("R9");
    cs = 1; cc = 1; tick("R10");
    cc = 1; tick("R9");
    cs = 1; tick("R10");
    cc = 1; tick("R9");

    // R11 set on a line lost in the same cycle
    rv = 1; rop = 2'd1; rline = 3'd2; rsub = 2'd1; ev = 1; evl = 3'd2; tick("R11");
    req(2'd1, 3, 0, "R11");
    rv = 1; rop = 2'd1; rline = 3'd3; rsub = 2'd2; sn = 1; snl = 3'd3; tick("R11");
    rv = 1; rop = 2'd1; rline = 3'd0; rsub = 2'd0; ca = 1; tick("R11");
    test_all("R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule